// File: doc/BRIEF.md
# Per-Area External Bus Cycle Controller

This block sits between an internal requester and an external asynchronous memory bus. Each request carries a 24-bit address. The block splits the address space into eight equal windows of 2 MB each, selected by the top three address bits. It runs an external read or write cycle using the timing programmed for the selected window, and it holds that window's active-low select line low for the whole cycle.

Each window has its own settings:
- a data width of 8 or 16 bits;
- a cycle length of two or three states;
- zero to three extra wait states, which are used only with three-state cycles.

A 16-bit transfer to an 8-bit window becomes two back-to-back byte cycles. The requester sees a single ready pulse when the whole transfer is done. A per-window direction bit decides whether that window's select pin is driven at all.

The requester raises `req_valid` with the address, size, direction and write data. It holds these values until `req_ready` pulses. Read data is valid in the ready cycle. Software-style configuration enters through a per-window write strobe and a separate direction-register write.

Top module: `area_bus_ctrl`

## Requirements
- R1: The window number is `req_addr[23:21]`. During an access, only that window's `cs_n` bit may be low. It stays low from the first to the last state of the access. No other `cs_n` bit is ever low.
- R2: `cs_oe[i]` equals direction bit i. A pin whose direction bit is 0 stays high even while its window is accessed. After reset the direction bits are 8'b0000_0001.
- R3: Width bit `cfg_narrow`: 0 means a 16-bit window and 1 means an 8-bit window. A 16-bit request to a 16-bit window uses one bus cycle, with `ext_addr` bit 0 forced to 0 and the full word on `ext_dout` / `ext_din`.
- R4: Cycle bit `cfg_slow`: 0 means a two-state cycle. The first state has no strobe. The strobe is low in the second state. `cfg_waits` has no effect in this mode.
- R5: With `cfg_slow` = 1, one bus cycle lasts 3+W states, where W is `cfg_waits` (0 to 3). The strobe is high in state 1, low in states 2 through 2+W, and high in the final state.
- R6: A 16-bit request to an 8-bit window runs two bus cycles. The first cycle uses the even address and the upper byte. The second uses the odd address and the lower byte. The select stays low across both cycles, and ready follows only the second.
- R7: `req_ready` is a one-cycle pulse in the final state of the access. It comes exactly N*L cycles after the accepting edge, where N is the number of bus cycles and L is the cycle length. `req_rdata` is valid in that cycle.
- R8: After reset every window is 8-bit, three-state, with 3 waits. A 16-bit request therefore takes 12 cycles.
- R9: Byte requests (`req_wide` = 0) run one bus cycle and return their byte in `req_rdata[7:0]`, with the upper bits 0. On an 8-bit window the byte uses lane [15:8]. On a 16-bit window an even address uses lane [15:8] and an odd address uses lane [7:0].
- R10: Writes drive `ext_wr_n` low in the strobe states and keep `ext_rd_n` high. Reads do the reverse. A byte written is placed on both halves of `ext_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until ready |
| req_addr | input | 24 | Byte address |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with ready |
| cfg_wr | input | 1 | Write timing of one window |
| cfg_area | input | 3 | Window being configured |
| cfg_narrow | input | 1 | 1 = 8-bit window |
| cfg_slow | input | 1 | 1 = three-state cycle |
| cfg_waits | input | 2 | Wait states for three-state cycles |
| dir_wr | input | 1 | Load direction bits |
| dir_in | input | 8 | New direction bits |
| ext_addr | output | 24 | External address |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| cs_n | output | 8 | Per-window select, active low |
| cs_oe | output | 8 | Per-window pin drive enable |

## Verification
The accepting edge is the first rising edge with `req_valid` high while the block is idle. Every bus-side output for state t of the access is due in the t-th cycle after that edge. `req_ready` and read data are due in cycle N*L, and the select lines return high in the following cycle.

The bench's reference model tracks t as an integer and samples each output at the falling edge of every such cycle. From t, the programmed window settings and the direction bits, it works out the expected strobe, address, write data, select pattern and ready. Configuration is changed only between accesses, so each model value refers to one known setting.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_STROBE,
      PH_WAIT,
      PH_END
   } bus_phase_e;

   typedef struct packed {
      logic       narrow;
      logic       slow;
      logic [1:0] waits;
   } area_cfg_t;

   localparam area_cfg_t CFG_RESET = '{narrow: 1'b1, slow: 1'b1, waits: 2'd3};
endpackage

// File: rtl/area_cfg_bank.sv
module area_cfg_bank
   import xbus_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter logic [NUM_AREAS-1:0] DIR_RESET = 'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_wr,
   input  logic [$clog2(NUM_AREAS)-1:0]   cfg_area,
   input  logic                           cfg_narrow,
   input  logic                           cfg_slow,
   input  logic [1:0]                     cfg_waits,
   input  logic                           dir_wr,
   input  logic [NUM_AREAS-1:0]           dir_in,
   output area_cfg_t [NUM_AREAS-1:0]      cfg_o,
   output logic [NUM_AREAS-1:0]           dir_o
);
   localparam int AB = $clog2(NUM_AREAS);

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_o[g] <= CFG_RESET;
         end else if (cfg_wr && cfg_area == AB'(g)) begin
            cfg_o[g] <= '{narrow: cfg_narrow, slow: cfg_slow, waits: cfg_waits};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_o <= DIR_RESET;
      else if (dir_wr) dir_o <= dir_in;
   end
endmodule

// File: rtl/area_decoder.sv
module area_decoder
   import xbus_pkg::*;
#(
   parameter int NUM_AREAS = 8
) (
   input  logic [$clog2(NUM_AREAS)-1:0] area_bits,
   input  area_cfg_t [NUM_AREAS-1:0]    cfg_all,
   output logic [$clog2(NUM_AREAS)-1:0] area_o,
   output area_cfg_t                    cfg_sel
);
   always_comb begin
      area_o  = area_bits;
      cfg_sel = cfg_all[area_bits];
   end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int AB     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wide,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [AB-1:0]     area_in,
   input  area_cfg_t         cfg_in,
   input  logic [DATA_W-1:0] ext_din,
   output logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic [DATA_W-1:0] ext_dout,
   output logic              busy,
   output logic [AB-1:0]     area_q
);
   localparam int HALF = DATA_W / 2;

   bus_phase_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, lat_q;
   logic [HALF-1:0]   hi_q;
   logic              wide_q, write_q, narrow_q, slow_q, second_q;
   logic [1:0]        waits_q, cnt_q;

   logic              two_cycle, final_st, last, strobe;
   logic [DATA_W-1:0] cur;
   logic [HALF-1:0]   out_byte, lane_byte;

   always_comb begin
      two_cycle = narrow_q & wide_q;
      final_st  = slow_q ? (state == PH_END) : (state == PH_STROBE);
      last      = !two_cycle || second_q;
      req_ready = final_st && last;
      busy      = (state != PH_IDLE);
      strobe    = (state == PH_STROBE) || (state == PH_WAIT);
      ext_rd_n  = !(strobe && !write_q);
      ext_wr_n  = !(strobe && write_q);
      cur       = (strobe && !write_q) ? ext_din : lat_q;
      out_byte  = (two_cycle && !second_q) ? wdata_q[DATA_W-1:HALF] : wdata_q[HALF-1:0];
      ext_dout  = (wide_q && !narrow_q) ? wdata_q : {out_byte, out_byte};
      if (two_cycle)   ext_addr = {addr_q[ADDR_W-1:1], second_q};
      else if (wide_q) ext_addr = {addr_q[ADDR_W-1:1], 1'b0};
      else             ext_addr = addr_q;
      lane_byte = (!narrow_q && addr_q[0]) ? cur[HALF-1:0] : cur[DATA_W-1:HALF];
      if (wide_q && !narrow_q) req_rdata = cur;
      else if (two_cycle)      req_rdata = {hi_q, cur[DATA_W-1:HALF]};
      else                     req_rdata = {{HALF{1'b0}}, lane_byte};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PH_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         lat_q    <= '0;
         hi_q     <= '0;
         wide_q   <= 1'b0;
         write_q  <= 1'b0;
         narrow_q <= 1'b0;
         slow_q   <= 1'b0;
         second_q <= 1'b0;
         waits_q  <= '0;
         cnt_q    <= '0;
         area_q   <= '0;
      end else begin
         if (strobe && !write_q) lat_q <= ext_din;
         if (final_st && two_cycle && !second_q) hi_q <= cur[DATA_W-1:HALF];
         unique case (state)
            PH_IDLE: if (req_valid) begin
               state    <= PH_ADDR;
               addr_q   <= req_addr;
               wdata_q  <= req_wdata;
               wide_q   <= req_wide;
               write_q  <= req_write;
               area_q   <= area_in;
               narrow_q <= cfg_in.narrow;
               slow_q   <= cfg_in.slow;
               waits_q  <= cfg_in.waits;
               second_q <= 1'b0;
            end
            PH_ADDR: state <= PH_STROBE;
            PH_STROBE: begin
               if (!slow_q) begin
                  if (last) state <= PH_IDLE;
                  else begin state <= PH_ADDR; second_q <= 1'b1; end
               end else if (waits_q != 2'd0) begin
                  cnt_q <= waits_q - 2'd1;
                  state <= PH_WAIT;
               end else begin
                  state <= PH_END;
               end
            end
            PH_WAIT: begin
               if (cnt_q == 2'd0) state <= PH_END;
               else               cnt_q <= cnt_q - 2'd1;
            end
            PH_END: begin
               if (last) state <= PH_IDLE;
               else begin state <= PH_ADDR; second_q <= 1'b1; end
            end
            default: state <= PH_IDLE;
         endcase
      end
   end

   // R5
   strobe_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(state) == PH_ADDR);
   // R4
   fast_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !slow_q) |-> (state != PH_WAIT && state != PH_END));
   // R6
   split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (final_st && !last) |=> (state == PH_ADDR && second_q));
   // R7
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);
endmodule

// File: rtl/area_bus_ctrl.sv
module area_bus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 16,
   parameter int NUM_AREAS = 8,
   parameter logic [NUM_AREAS-1:0] DIR_RESET = 'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_wide,
   input  logic                          req_write,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          req_ready,
   output logic [DATA_W-1:0]             req_rdata,
   input  logic                          cfg_wr,
   input  logic [$clog2(NUM_AREAS)-1:0]  cfg_area,
   input  logic                          cfg_narrow,
   input  logic                          cfg_slow,
   input  logic [1:0]                    cfg_waits,
   input  logic                          dir_wr,
   input  logic [NUM_AREAS-1:0]          dir_in,
   output logic [ADDR_W-1:0]             ext_addr,
   output logic                          ext_rd_n,
   output logic                          ext_wr_n,
   output logic [DATA_W-1:0]             ext_dout,
   input  logic [DATA_W-1:0]             ext_din,
   output logic [NUM_AREAS-1:0]          cs_n,
   output logic [NUM_AREAS-1:0]          cs_oe
);
   localparam int AB = $clog2(NUM_AREAS);

   if ((1 << AB) != NUM_AREAS || NUM_AREAS < 2) begin : g_bad_areas
      $error("NUM_AREAS must be a power of two, at least 2");
   end
   if (ADDR_W <= AB + 1) begin : g_bad_addr
      $error("ADDR_W too small for the area count");
   end
   if (DATA_W % 2 != 0) begin : g_bad_data
      $error("DATA_W must be even");
   end

   area_cfg_t [NUM_AREAS-1:0] cfg_all;
   area_cfg_t                 cfg_sel;
   logic [NUM_AREAS-1:0]      dir;
   logic [AB-1:0]             area_dec, area_q;
   logic                      busy;

   area_cfg_bank #(.NUM_AREAS(NUM_AREAS), .DIR_RESET(DIR_RESET)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_area(cfg_area),
      .cfg_narrow(cfg_narrow), .cfg_slow(cfg_slow), .cfg_waits(cfg_waits),
      .dir_wr(dir_wr), .dir_in(dir_in), .cfg_o(cfg_all), .dir_o(dir)
   );

   area_decoder #(.NUM_AREAS(NUM_AREAS)) u_dec (
      .area_bits(req_addr[ADDR_W-1 -: AB]), .cfg_all(cfg_all),
      .area_o(area_dec), .cfg_sel(cfg_sel)
   );

   bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AB(AB)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wide(req_wide), .req_write(req_write), .req_wdata(req_wdata),
      .area_in(area_dec), .cfg_in(cfg_sel), .ext_din(ext_din),
      .req_ready(req_ready), .req_rdata(req_rdata), .ext_addr(ext_addr),
      .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_dout(ext_dout),
      .busy(busy), .area_q(area_q)
   );

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
      assign cs_n[g]  = dir[g] ? !(busy && area_q == AB'(g)) : 1'b1;
      assign cs_oe[g] = dir[g];
   end

   // R1
   cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R2
   cs_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      &(cs_n | cs_oe));
   // R1
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd_n && ext_wr_n && !busy) |-> (&cs_n));
endmodule

// File: tb/sim_area_bus_ctrl.sv
module sim_area_bus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_wide = 1'b0, req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] req_rdata;
   logic        cfg_wr = 1'b0, cfg_narrow = 1'b0, cfg_slow = 1'b0;
   logic [2:0]  cfg_area = '0;
   logic [1:0]  cfg_waits = '0;
   logic        dir_wr = 1'b0;
   logic [7:0]  dir_in = '0;
   logic [23:0] ext_addr;
   logic        ext_rd_n, ext_wr_n;
   logic [15:0] ext_dout, ext_din;
   logic [7:0]  cs_n, cs_oe;

   int checks = 0, failures = 0, cycles = 0;
   logic       m_narrow[8], m_slow[8];
   logic [1:0] m_waits[8];
   logic [7:0] m_dir;

   always #10 clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [23:0] a);
      return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
   endfunction
   assign ext_din = mem_word(ext_addr);

   area_bus_ctrl u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            chk(1'b0, "R7", "watchdog expired", cycles, 150000);
            summary();
         end
      end
   end

   task automatic set_area(input int a, input logic n, input logic s, input logic [1:0] w);
      @(negedge clk);
      cfg_wr = 1; cfg_area = 3'(a); cfg_narrow = n; cfg_slow = s; cfg_waits = w;
      @(negedge clk);
      cfg_wr = 0;
      m_narrow[a] = n; m_slow[a] = s; m_waits[a] = w;
   endtask

   task automatic set_dir(input logic [7:0] d);
      @(negedge clk);
      dir_wr = 1; dir_in = d;
      @(negedge clk);
      dir_wr = 0;
      m_dir = d;
   endtask

   // Reference model: one access, compared on every cycle.
   task automatic access(input logic [23:0] a, input logic wide, input logic wr,
                         input logic [15:0] wd);
      int   ar = int'(a[23:21]);
      logic nar = m_narrow[ar], slw = m_slow[ar];
      int   w = int'(m_waits[ar]);
      int   len = slw ? 3 + w : 2;
      int   nb = (nar && wide) ? 2 : 1;
      int   total = len * nb;
      string tmode = (nb == 2) ? "R6" : (slw ? "R5" : "R4");
      logic [7:0] exp_cs = 8'hFF;
      logic [15:0] exp_rd;
      if (m_dir[ar]) exp_cs[ar] = 1'b0;
      if (wide && !nar)    exp_rd = mem_word({a[23:1], 1'b0});
      else if (nb == 2)    exp_rd = {mem_word({a[23:1], 1'b0})[15:8], mem_word({a[23:1], 1'b1})[15:8]};
      else if (nar)        exp_rd = {8'h00, mem_word(a)[15:8]};
      else                 exp_rd = {8'h00, a[0] ? mem_word(a)[7:0] : mem_word(a)[15:8]};
      @(negedge clk);
      req_valid = 1; req_addr = a; req_wide = wide; req_write = wr; req_wdata = wd;
      for (int t = 1; t <= total; t++) begin
         int   s = (t - 1) % len;
         int   b = (t - 1) / len;
         logic stb = slw ? (s >= 1 && s <= len - 2) : (s == 1);
         logic [23:0] exp_a;
         logic [7:0]  byt;
         logic [15:0] exp_do;
         @(negedge clk);
         if (nb == 2)   exp_a = {a[23:1], b[0]};
         else if (wide) exp_a = {a[23:1], 1'b0};
         else           exp_a = a;
         byt = (nb == 2 && b == 0) ? wd[15:8] : wd[7:0];
         exp_do = (wide && !nar) ? wd : {byt, byt};
         chk(req_ready == (t == total), "R7", "ready timing", {req_ready, 8'(t)}, {(t == total), 8'(t)});
         chk(cs_n == exp_cs, m_dir[ar] ? "R1" : "R2", "chip selects", cs_n, exp_cs);
         chk(ext_addr == exp_a, (nb == 2) ? "R6" : "R3", "address", ext_addr, exp_a);
         chk(ext_rd_n == !(stb && !wr), tmode, "read strobe", ext_rd_n, !(stb && !wr));
         chk(ext_wr_n == !(stb && wr), "R10", "write strobe", ext_wr_n, !(stb && wr));
         if (wr) chk(ext_dout == exp_do, "R10", "write data", ext_dout, exp_do);
         if (t == total) begin
            if (!wr) chk(req_rdata == exp_rd, wide ? ((nb == 2) ? "R6" : "R3") : "R9",
                         "read data", req_rdata, exp_rd);
            req_valid = 0;
         end
         if (req_ready) break;
      end
      @(negedge clk);
      chk(cs_n == 8'hFF && !req_ready, "R7", "idle after access", {req_ready, cs_n}, {1'b0, 8'hFF});
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_narrow[i] = 1; m_slow[i] = 1; m_waits[i] = 3;
      end
      m_dir = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cs_n == 8'hFF, "R2", "reset cs_n", cs_n, 8'hFF);
      chk(cs_oe == 8'h01, "R2", "reset direction", cs_oe, 8'h01);
      chk(!req_ready && ext_rd_n && ext_wr_n, "R7", "reset strobes",
          {req_ready, ext_rd_n, ext_wr_n}, 3'b011);
      // R8: reset config gives 12-cycle split access on area 0
      access(24'h000010, 1, 0, 16'h0);
      // R2: area 1 not driven by default
      access(24'h200020, 1, 1, 16'hBEEF);
      set_dir(8'hFF);
      chk(cs_oe == 8'hFF, "R2", "direction load", cs_oe, 8'hFF);
      for (int i = 0; i < 16; i++) begin
         int a = i % 8;
         logic [23:0] ad = {3'(a), 13'h0, 8'(i * 16 + 2)};
         set_area(a, i[3], i[2], i[1:0]);
         access(ad, 1, 0, 16'h0);
         access(ad, 1, 1, 16'h1234 + 16'(i * 257));
         access(ad | 24'h1, 0, 0, 16'h0);
         access(ad, 0, 0, 16'h0);
         access(ad | 24'h1, 0, 1, 16'h00C0 + 16'(i));
      end
      // R1: decode across every area with fast 16-bit timing
      for (int a = 0; a < 8; a++) begin
         set_area(a, 0, 0, 2'd3);
         access({3'(a), 21'h0ABCD4}, 1, 0, 16'h0);
      end
      set_dir(8'h5A);
      for (int a = 0; a < 8; a++) access({3'(a), 21'h000100}, 1, 1, 16'hA5A5);
      summary();
   end
endmodule